// File: doc/BRIEF.md
# Cascadable Active-Low Priority Encoder

This block turns a set of request lines into the binary number of the most important active line. Any number of requests may be active together. Only the request with the highest rank is reported, so the result is never a blend of several codes. Every request line and every output is active low. A request is asserted by driving it to 0, and the reported code is the bitwise inverse of the winning index.

The building unit is a slice with eight requests by default. Each slice has an enable input, a group-select output and an enable output. A slice that is enabled but idle asserts its enable output, which hands the enable to the next slice down the priority chain.

The top level chains two slices into a 16-request encoder. The upper slice serves requests 8 to 15 and takes the external enable. Its enable output feeds the lower slice, which serves requests 0 to 7. The 4-bit code is built from two parts. Its top bit is the upper slice's group select. Its three low bits are the AND of both slices' active-low codes. There is no clock and no stored state: every output follows the inputs combinationally.

Top module: `prienc_cascade`

## Requirements
- R1: Among the asserted requests, the one with the largest index wins. Index 15 outranks every other request, and index 0 ranks lowest.
- R2: A request is asserted when its line is 0. The code output is active low: `code_n` equals the bitwise inverse of the winning index, so index 5 reads 4'b1010 and index 15 reads 4'b0000.
- R3: While `en_in_n` is 1, all outputs are 1 whatever the requests: `code_n` = 4'b1111, `grp_n` = 1 and `en_out_n` = 1.
- R4: `grp_n` is 0 exactly when `en_in_n` is 0 and at least one request is asserted.
- R5: `en_out_n` is 0 exactly when `en_in_n` is 0 and no request is asserted.
- R6: When the block is enabled and no request is asserted, `code_n` reads 4'b1111, the same as index 0. Only `grp_n` separates the two cases.
- R7: When any of requests 8 to 15 is asserted and the block is enabled, `code_n[3]` is 0, and requests 0 to 7 have no effect on any output.
- R8: Requests 0 to 7 are reported, with `code_n[3]` = 1, only when the block is enabled and requests 8 to 15 are all idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_n | input | 16 | Request lines, active low; bit i is request i |
| en_in_n | input | 1 | Enable input, active low |
| code_n | output | 4 | Winning index, active low (inverted binary) |
| grp_n | output | 1 | Low when enabled and at least one request is asserted |
| en_out_n | output | 1 | Low when enabled and no request is asserted; feeds the next lower-priority stage |

## Verification
The bench uses the default slice width of eight. This makes the full request space 2^16 patterns, small enough to sweep completely with the block enabled. That sweep reaches every priority ordering, every hand-off from the upper slice to the lower slice, and the all-idle pattern. Random patterns with the block disabled confirm that the enable silences every output. Directed vectors pin down the single-request codes at both ends of each slice.

// File: rtl/prienc_pkg.sv
package prienc_pkg;
  // Requests served by one slice unless overridden.
  localparam int unsigned SLICE_W_DEF = 8;

  // Width of a slice's binary code for a given slice size.
  function automatic int unsigned code_bits(input int unsigned w);
    return (w > 1) ? $clog2(w) : 1;
  endfunction
endpackage

// File: rtl/prienc_pick.sv
module prienc_pick #(
  parameter int unsigned W  = prienc_pkg::SLICE_W_DEF,
  localparam int unsigned IW = prienc_pkg::code_bits(W)
) (
  input  logic [W-1:0]  act,
  output logic          any,
  output logic [IW-1:0] idx
);
  // Scan upward so the highest active line is the last one kept.
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (act[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end

  always_comb begin
    // R1
    pick_top_chk: assert (!act[W-1] || (idx == IW'(W-1)));
    // R6
    pick_idle_chk: assert (any || (idx == '0));
  end
endmodule

// File: rtl/prienc_slice.sv
module prienc_slice #(
  parameter int unsigned W  = prienc_pkg::SLICE_W_DEF,
  localparam int unsigned IW = prienc_pkg::code_bits(W)
) (
  input  logic [W-1:0]  req_n,
  input  logic          en_in_n,
  output logic [IW-1:0] code_n,
  output logic          grp_n,
  output logic          en_out_n
);
  logic [W-1:0]  act;
  logic          any;
  logic [IW-1:0] idx;
  logic          on;

  assign act = ~req_n;
  assign on  = ~en_in_n;

  prienc_pick #(.W(W)) u_pick (
    .act (act),
    .any (any),
    .idx (idx)
  );

  assign code_n   = on ? ~idx : '1;
  assign grp_n    = ~(on & any);
  assign en_out_n = ~(on & ~any);

  always_comb begin
    // R3
    off_quiet_chk: assert (!en_in_n || ((&code_n) && grp_n && en_out_n));
    // R4
    one_status_chk: assert (en_in_n || (grp_n != en_out_n));
    // R5
    idle_pass_chk: assert (en_in_n || (en_out_n == (|act)));
  end
endmodule

// File: rtl/prienc_cascade.sv
module prienc_cascade #(
  parameter int unsigned SLICE_W = prienc_pkg::SLICE_W_DEF,
  localparam int unsigned IW     = prienc_pkg::code_bits(SLICE_W),
  localparam int unsigned TOT    = 2 * SLICE_W
) (
  input  logic [TOT-1:0] req_n,
  input  logic           en_in_n,
  output logic [IW:0]    code_n,
  output logic           grp_n,
  output logic           en_out_n
);
  logic [IW-1:0] hi_code_n, lo_code_n;
  logic          hi_grp_n, lo_grp_n;
  logic          hand_n, lo_eo_n;

  prienc_slice #(.W(SLICE_W)) u_hi (
    .req_n    (req_n[TOT-1:SLICE_W]),
    .en_in_n  (en_in_n),
    .code_n   (hi_code_n),
    .grp_n    (hi_grp_n),
    .en_out_n (hand_n)
  );

  prienc_slice #(.W(SLICE_W)) u_lo (
    .req_n    (req_n[SLICE_W-1:0]),
    .en_in_n  (hand_n),
    .code_n   (lo_code_n),
    .grp_n    (lo_grp_n),
    .en_out_n (lo_eo_n)
  );

  assign code_n   = {hi_grp_n, hi_code_n & lo_code_n};
  assign grp_n    = hi_grp_n & lo_grp_n;
  assign en_out_n = lo_eo_n;

  always_comb begin
    // R1
    top_wins_chk: assert (en_in_n || req_n[TOT-1] || (code_n == '0));
    // R7
    upper_first_chk: assert (en_in_n || (&req_n[TOT-1:SLICE_W]) || !code_n[IW]);
    // R8
    lower_gate_chk: assert ((&req_n[TOT-1:SLICE_W]) || en_in_n || lo_grp_n);
  end
endmodule

// File: tb/prienc_cascade_tb.sv
module prienc_cascade_tb;
  logic        clk = 1'b0;
  logic [15:0] req_n = '1;
  logic        en_in_n = 1'b1;
  logic [3:0]  code_n;
  logic        grp_n;
  logic        en_out_n;
  int          n_chk = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  prienc_cascade u_dut (
    .req_n    (req_n),
    .en_in_n  (en_in_n),
    .code_n   (code_n),
    .grp_n    (grp_n),
    .en_out_n (en_out_n)
  );

  // Expected {code_n, grp_n, en_out_n} from the requirements.
  function automatic logic [5:0] model(input logic [15:0] act, input logic en_n);
    int win;
    win = -1;
    if (en_n) return 6'b111111;
    for (int i = 0; i < 16; i++) if (act[i]) win = i;
    if (win < 0) return {4'b1111, 1'b1, 1'b0};
    return {~4'(win), 1'b0, 1'b1};
  endfunction

  task automatic apply(input logic [15:0] act, input logic en_n, input string tag);
    logic [5:0] exp_v, got;
    @(posedge clk);
    req_n   = ~act;
    en_in_n = en_n;
    @(negedge clk);
    exp_v = model(act, en_n);
    got   = {code_n, grp_n, en_out_n};
    n_chk++;
    if (got !== exp_v) begin
      n_bad++;
      $display("FAIL %s act=%h en_n=%b got=%b expected=%b", tag, act, en_n, got, exp_v);
    end
  endtask

  function automatic string tag_of(input logic [15:0] act);
    if (act == 16'h0) return "R5";
    if (|act[15:8])   return "R7";
    return "R8";
  endfunction

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad + 1, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R3: quiet reset-like state with enable off
    apply(16'h0000, 1'b1, "R3");
    apply(16'hFFFF, 1'b1, "R3");
    // R2: single requests at each slice boundary
    apply(16'h0020, 1'b0, "R2");
    apply(16'h8000, 1'b0, "R2");
    apply(16'h0100, 1'b0, "R2");
    apply(16'h0080, 1'b0, "R2");
    // R6: idle vs index 0 share code, grp_n differs
    apply(16'h0000, 1'b0, "R6");
    apply(16'h0001, 1'b0, "R6");
    // R4: multiple requests
    apply(16'h00FF, 1'b0, "R4");
    apply(16'hFFFF, 1'b0, "R1");
    // R3: random patterns with enable off
    for (int k = 0; k < 500; k++) apply(16'($urandom), 1'b1, "R3");
    // R1, R7, R8: full sweep enabled
    for (int v = 0; v < 65536; v++) apply(16'(v), 1'b0, tag_of(16'(v)));
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule